// File: doc/BRIEF.md
# Paged Register Window Controller

This block puts a bank of paged registers behind a fixed sixteen-address window at the top of an 8-bit register address space (F0h to FFh). A pointer register at a fixed system address picks one of up to 64 pages. Each page holds sixteen 8-bit registers. Every window read or write goes to the page that the pointer currently selects. Software sets the pointer once and can then reach any register of that page through the window, without writing the pointer again.

The configuration mask, given as a parameter, decides which pages are built. A page whose mask bit is clear has no storage. Reads from it return zero and writes to it are dropped. The bus is a plain synchronous register port. Reads are registered, so the read data appears one cycle after the read strobe.

Top module: `paged_window_ctrl`

## Requirements
- R1: A write to address EAh loads write-data bits 7:2 into the 6-bit page pointer. A read of EAh returns the page number in bits 7:2. All six pointer bits are kept, including values of NUM_PAGES and above.
- R2: Bits 1:0 of a pointer read are always 0, whatever was written to them.
- R3: An access to an address whose bits 7:4 equal Fh reaches register index = address bits 3:0 of the selected page. F2h reaches index 2, the third register. A written value reads back unchanged.
- R4: Each page has its own storage. The same window index on two present pages holds two independent values, and changing the pointer changes what the window shows.
- R5: Several accesses in a row to different indices of one page need only one pointer write before them.
- R6: When the selected page has its mask bit clear, window reads return 00h and window writes change no register on any page.
- R7: A pointer value of NUM_PAGES or more selects no page. Window reads return 00h and window writes change no register. The value does not wrap onto a lower page.
- R8: An address that is neither EAh nor in F0h to FFh reads as 00h. A write to such an address changes neither the pointer nor any page register.
- R9: Read data changes on the clock edge where read enable is sampled high, and only then. It keeps its value while read enable is low.
- R10: After reset the read data is 00h and every register of every present page holds 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| addr | input | 8 | Register address of the access |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, acts at the rising edge |
| re | input | 1 | Read strobe. Read data is registered at the rising edge |
| rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with NUM_PAGES = 8 and the mask 8'b1011_0101. That gives a mix of present pages (0, 2, 4, 5, 7) and absent ones (1, 3, 6) within eight pages, so sixteen registers on each page can be filled and read back in a short run. The 6-bit pointer can then also hold values above the last built page. The bench uses pointer value 13 to show that such a value does not fold onto page 5 through the low address bits. Writes made while an absent page is selected are checked by reading the same index on every present page.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned ADDR_W = 8;
    parameter int unsigned PG_W   = 6;
    parameter int unsigned IDX_W  = 4;

    localparam int unsigned PAD_W     = DATA_W - PG_W;
    localparam int unsigned MAX_PAGES = 1 << PG_W;
    localparam int unsigned ENTRIES   = 1 << IDX_W;
    localparam int unsigned TAG_W     = ADDR_W - IDX_W;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_WIN  = 2'd2
    } sel_e;

    typedef struct packed {
        logic [PG_W-1:0]   page;
        logic [DATA_W-1:0] rdata;
    } ctl_state_t;
endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode
    import pgwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PTR_ADDR = 8'hEA,
    parameter logic [TAG_W-1:0]  WIN_TAG  = 4'hF
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        idx = addr[IDX_W-1:0];
        if (addr == PTR_ADDR) begin
            sel = SEL_PTR;
        end else if (addr[ADDR_W-1:IDX_W] == WIN_TAG) begin
            sel = SEL_WIN;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/pgwin_bank.sv
module pgwin_bank
    import pgwin_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);
    generate
        if (PRESENT) begin : g_mem
            logic [ENTRIES-1:0][DATA_W-1:0] mem_d, mem_q;

            always_comb begin
                mem_d = mem_q;
                if (wr_en) begin
                    mem_d[idx] = wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_q <= '0;
                end else begin
                    mem_q <= mem_d;
                end
            end

            assign rd_data = mem_q[idx];

            // R3: a register that is not written keeps its value
            a_r3_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(mem_q));
        end else begin : g_none
            logic unused_bank_inputs;
            assign unused_bank_inputs = ^{idx, wdata};
            assign rd_data = '0;

            // R6: the controller never strobes a page that is not built
            a_r6_no_write_absent: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en);
        end
    endgenerate
endmodule

// File: rtl/paged_window_ctrl.sv
module paged_window_ctrl
    import pgwin_pkg::*;
#(
    parameter int unsigned          NUM_PAGES    = 64,
    parameter logic [NUM_PAGES-1:0] PRESENT_MASK = '1,
    parameter logic [ADDR_W-1:0]    PTR_ADDR     = 8'hEA,
    parameter logic [TAG_W-1:0]     WIN_TAG      = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [MAX_PAGES-1:0] FULL_MASK = MAX_PAGES'(PRESENT_MASK);

    sel_e                             sel;
    logic [IDX_W-1:0]                 idx;
    ctl_state_t                       st_d, st_q;
    logic [NUM_PAGES-1:0]             page_we;
    logic [NUM_PAGES-1:0][DATA_W-1:0] page_rd;
    logic [DATA_W-1:0]                win_rd;

    pgwin_decode #(
        .PTR_ADDR (PTR_ADDR),
        .WIN_TAG  (WIN_TAG)
    ) u_decode (
        .addr (addr),
        .sel  (sel),
        .idx  (idx)
    );

    generate
        for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
            assign page_we[p] = FULL_MASK[p] && we && (sel == SEL_WIN)
                                && (st_q.page == PG_W'(p));
            pgwin_bank #(
                .PRESENT (FULL_MASK[p])
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (page_we[p]),
                .idx     (idx),
                .wdata   (wdata),
                .rd_data (page_rd[p])
            );
        end
    endgenerate

    always_comb begin
        win_rd = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (st_q.page == PG_W'(p)) begin
                win_rd = page_rd[p];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (we && sel == SEL_PTR) begin
            st_d.page = wdata[DATA_W-1:PAD_W];
        end
        if (re) begin
            case (sel)
                SEL_PTR: st_d.rdata = {st_q.page, {PAD_W{1'b0}}};
                SEL_WIN: st_d.rdata = win_rd;
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    // R1 / R8: the pointer moves only on a write to its own address
    a_r1_ptr_only_own_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == PTR_ADDR) |=> $stable(st_q.page));
    // R1: pointer read returns the page held before the read
    a_r1_ptr_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr == PTR_ADDR) |=> rdata[DATA_W-1:PAD_W] == $past(st_q.page));
    // R2: low pointer bits read as zero
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr == PTR_ADDR) |=> rdata[PAD_W-1:0] == '0);
    // R4: at most one page is written per cycle
    a_r4_one_page_written: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_we));
    // R6 / R7: an unbuilt or out-of-range page reads as zero
    a_r6_absent_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr[ADDR_W-1:IDX_W] == WIN_TAG && !FULL_MASK[st_q.page])
        |=> rdata == '0);
    // R8: unmapped addresses read as zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr != PTR_ADDR && addr[ADDR_W-1:IDX_W] != WIN_TAG) |=> rdata == '0);
    // R9: read data holds while no read is strobed
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
endmodule

// File: tb/paged_window_ctrl_bench.sv
module paged_window_ctrl_bench;
    localparam int NP = 8;
    localparam logic [NP-1:0] MASK = 8'b1011_0101;
    localparam logic [7:0] PTR = 8'hEA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [7:0] rdata;

    int total = 0;
    int fails = 0;
    logic [7:0] exp_mem [NP][16];

    always #2.5 clk = ~clk;

    paged_window_ctrl #(
        .NUM_PAGES    (NP),
        .PRESENT_MASK (MASK)
    ) u_paged_window_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .we    (we),
        .re    (re),
        .rdata (rdata)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1; re = 1'b0;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; re = 1'b1; we = 1'b0;
        @(negedge clk);
        re = 1'b0;
        v = rdata;
    endtask

    task automatic set_page(input int p);
        wr(PTR, {6'(p), 2'b11});
    endtask

    function automatic bit present(input int p);
        return (p < NP) && MASK[p];
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        check("R10 rdata after reset", rdata, 8'h00);
        set_page(2);
        for (int i = 0; i < 4; i++) begin
            rd(8'hF0 + 8'(i), v);
            check("R10 page 2 register clear", v, 8'h00);
        end
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        wr(PTR, 8'h17);
        rd(PTR, v);
        check("R1 pointer readback 5", v, 8'h14);
        wr(PTR, 8'hFF);
        rd(PTR, v);
        check("R2 low bits zero on FFh", v, 8'hFC);
        wr(PTR, 8'h02);
        rd(PTR, v);
        check("R2 low bits zero on 02h", v, 8'h00);
    endtask

    task automatic t_fill();
        logic [7:0] v;
        for (int p = 0; p < NP; p++) begin
            if (present(p)) begin
                set_page(p);
                for (int i = 0; i < 16; i++) begin
                    exp_mem[p][i] = 8'((p * 16 + i) ^ 8'h5A);
                    wr(8'hF0 + 8'(i), exp_mem[p][i]);
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (present(p)) begin
                set_page(p);
                for (int i = 0; i < 16; i++) begin
                    rd(8'hF0 + 8'(i), v);
                    check("R5 R3 sequential page readback", v, exp_mem[p][i]);
                end
            end
        end
    endtask

    task automatic t_index();
        logic [7:0] v;
        set_page(5);
        wr(8'hF2, 8'hC3);
        exp_mem[5][2] = 8'hC3;
        rd(8'hF2, v);
        check("R3 F2h is index 2", v, 8'hC3);
        rd(8'hF1, v);
        check("R3 index 1 untouched", v, exp_mem[5][1]);
        rd(8'hF3, v);
        check("R3 index 3 untouched", v, exp_mem[5][3]);
    endtask

    task automatic t_independent();
        logic [7:0] v;
        set_page(0);
        wr(8'hF7, 8'h11);
        exp_mem[0][7] = 8'h11;
        set_page(2);
        wr(8'hF7, 8'h22);
        exp_mem[2][7] = 8'h22;
        set_page(0);
        rd(8'hF7, v);
        check("R4 page 0 keeps own value", v, 8'h11);
        set_page(2);
        rd(8'hF7, v);
        check("R4 page 2 keeps own value", v, 8'h22);
    endtask

    task automatic scan_index(input string tag, input int i);
        logic [7:0] v;
        for (int p = 0; p < NP; p++) begin
            if (present(p)) begin
                set_page(p);
                rd(8'hF0 + 8'(i), v);
                check(tag, v, exp_mem[p][i]);
            end
        end
    endtask

    task automatic t_absent();
        logic [7:0] v;
        set_page(3);
        wr(8'hF2, 8'hEE);
        rd(8'hF2, v);
        check("R6 absent page 3 reads zero", v, 8'h00);
        set_page(6);
        wr(8'hF2, 8'hDD);
        rd(8'hF2, v);
        check("R6 absent page 6 reads zero", v, 8'h00);
        scan_index("R6 absent write lands nowhere", 2);
    endtask

    task automatic t_out_range();
        logic [7:0] v;
        set_page(13);
        rd(PTR, v);
        check("R1 R7 pointer keeps 13", v, 8'h34);
        rd(8'hF5, v);
        check("R7 page 13 reads zero", v, 8'h00);
        wr(8'hF5, 8'h99);
        rd(8'hF5, v);
        check("R7 page 13 write ignored", v, 8'h00);
        scan_index("R7 no wrap onto low page", 5);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        set_page(4);
        wr(8'h80, 8'h77);
        wr(8'hE9, 8'h55);
        wr(8'hEB, 8'h66);
        wr(8'hEF, 8'h44);
        rd(8'h80, v);
        check("R8 80h reads zero", v, 8'h00);
        rd(8'hE9, v);
        check("R8 E9h reads zero", v, 8'h00);
        rd(8'hEB, v);
        check("R8 EBh reads zero", v, 8'h00);
        rd(PTR, v);
        check("R8 pointer unchanged", v, 8'h10);
        for (int i = 0; i < 16; i++) begin
            rd(8'hF0 + 8'(i), v);
            check("R8 page 4 unchanged", v, exp_mem[4][i]);
        end
    endtask

    task automatic t_hold();
        logic [7:0] v;
        set_page(7);
        rd(8'hF4, v);
        check("R9 first read", v, exp_mem[7][4]);
        @(negedge clk);
        addr = 8'hF5;
        re = 1'b1;
        #1;
        check("R9 no change before edge", rdata, exp_mem[7][4]);
        @(negedge clk);
        re = 1'b0;
        check("R9 new data after edge", rdata, exp_mem[7][5]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            addr = 8'hF0 + 8'(k);
            wdata = 8'hA5;
        end
        @(negedge clk);
        check("R9 holds while idle", rdata, exp_mem[7][5]);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < 16; i++) begin
                exp_mem[p][i] = 8'h00;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_fill();
        t_index();
        t_independent();
        t_absent();
        t_out_range();
        t_unmapped();
        t_hold();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule